// File: doc/BRIEF.md
# Banked ROM Address Mapper

This block sits between a CPU bus and a cartridge-style program ROM and turns each 24-bit CPU address into a ROM address. Two translation schemes share it. Addresses with bit 22 set fall into a linear high region split into four 1 MiB quarters. Each quarter takes its upper ROM address bits from its own bank-select register. Addresses with bit 22 clear use the lower half-bank scheme. That scheme packs the upper 32 KiB of each 64 KiB CPU bank back to back. A control bit can fold the upper part of this region onto the lower part, separately for the two halves of the CPU address space.

Software reaches the bank registers and two general control bytes through a 16-byte I/O window. A chip-level decoder asserts `ioSel` for that window, and the mapper looks only at address bits 3:0 inside it. Offsets that hold no register pass ROM data through. During such an access the ROM address points at the window address itself. Register writes are clocked. Translation and reads are combinational.

Top module: `bank_rom_mapper`

## Requirements
- R1: After reset, the bank registers at window offsets 4, 5, 6 and 7 read 0x00, 0x01, 0x02 and 0x03, and the control bytes at offsets 0 and 1 read 0x00.
- R2: A write to a bank register stores only bits 7 and 3:0 of the written byte (mask 0x8f). Bits 6:4 read back as zero.
- R3: Control bytes at offsets 0 and 1 store and return all eight written bits.
- R4: Inside the window only `cpuAddr[3:0]` selects the register. Other address bits have no effect on which register is written or read.
- R5: A read at offsets 2, 3 or 8 to 15 returns `romData`. While `ioSel` is high, `romAddr` equals 0x004800 with `cpuAddr[3:0]` in its low nibble. A write at those offsets changes no register.
- R6: With `ioSel` low and `cpuAddr[22]` set, `cpuAddr[21:20]` selects bank register 0 to 3. `romAddr` is that register's bits 3:0 in bits 23:20, followed by `cpuAddr[19:0]`.
- R7: With `ioSel` low and `cpuAddr[22]` clear, `romAddr` = ((a >> 1) & 0x1f8000) | (a & 0x7fff), where a is the CPU address after any fold of R8/R9.
- R8: When `cpuAddr[23]` is clear, `cpuAddr[21]` is set and bit 7 of bank register 1 is set, bit 21 is cleared before the R7 translation.
- R9: When `cpuAddr[23]` is set, `cpuAddr[21]` is set and bit 7 of bank register 3 is set, bit 21 is cleared before the R7 translation. Bit 7 of register 1 has no effect on this half, and bit 7 of register 3 has no effect on the R8 half.
- R10: A register changes only on the clock edge where `ioSel` and `ioWr` are both high. The new value is visible right after that edge. `rdData` is 0 while `ioRd` or `ioSel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 24 | CPU bus address |
| ioSel | input | 1 | High when the CPU addresses the 16-byte register window |
| ioWr | input | 1 | Write strobe for the window |
| ioRd | input | 1 | Read strobe for the window |
| wrData | input | 8 | Write data |
| romData | input | 8 | ROM byte passed through at non-register offsets |
| rdData | output | 8 | Read data |
| romAddr | output | 24 | Translated ROM address |

## Verification
The bench builds the mapper with its default four bank registers, each with a 4-bit bank field. At this size every register, both fold bits and all four high-region quarters can be reached directly. Walking the window offsets from 0 to 15 with different upper address bits covers the masked writes, the unmapped offsets and the alias rule. Address pairs with bit 23 clear and set, taken with each fold bit alone, show that each flag acts only on its own half.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  localparam int NUM_BANKS  = 4;
  localparam int DATA_W     = 8;
  localparam int OFF_W      = 4;
  localparam int ADDR_W     = 24;
  localparam int BANK_SEL_W = 4;
  localparam int WIN_BITS   = 20;
  localparam int HALF_BITS  = 15;
  localparam int BANK_BASE  = 4;
  localparam logic [DATA_W-1:0] BANK_KEEP = 8'h8f;
  localparam logic [ADDR_W-1:0] IO_BASE   = 24'h004800;

  typedef struct packed {
    logic                 wrCtl0;
    logic                 wrCtl1;
    logic [NUM_BANKS-1:0] wrBank;
    logic                 rdEn;
    logic                 rdReg;
    logic [OFF_W-1:0]     off;
  } ioStrobe_t;
endpackage

// File: rtl/bankmap_ctrl.sv
module bankmap_ctrl
  import bankmap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioSel,
  input  logic             ioWr,
  input  logic             ioRd,
  input  logic [OFF_W-1:0] ioOff,
  output ioStrobe_t        strobe
);
  logic [NUM_BANKS-1:0] bankHit;
  logic                 isReg;
  logic                 wrGo;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign bankHit[b] = (ioOff == OFF_W'(BANK_BASE + b));
  end

  assign isReg = (ioOff == OFF_W'(0)) || (ioOff == OFF_W'(1)) || (|bankHit);
  assign wrGo  = ioSel && ioWr;

  always_comb begin
    strobe        = '0;
    strobe.off    = ioOff;
    strobe.rdEn   = ioSel && ioRd;
    strobe.rdReg  = ioSel && ioRd && isReg;
    strobe.wrCtl0 = wrGo && (ioOff == OFF_W'(0));
    strobe.wrCtl1 = wrGo && (ioOff == OFF_W'(1));
    strobe.wrBank = wrGo ? bankHit : '0;
  end

  // R10: at most one register is targeted by any write
  p_single_target_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrCtl0, strobe.wrCtl1, strobe.wrBank}));

  // R5: unmapped offsets never raise a write strobe
  p_unmapped_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ioOff == OFF_W'(2) || ioOff == OFF_W'(3) || ioOff >= OFF_W'(BANK_BASE + NUM_BANKS))
      |-> (strobe.wrCtl0 == 1'b0 && strobe.wrCtl1 == 1'b0 && strobe.wrBank == '0));
endmodule

// File: rtl/bankmap_datapath.sv
module bankmap_datapath
  import bankmap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobe_t         strobe,
  input  logic              ioSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] romData,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] romAddr
);
  localparam int SEL_W       = $clog2(NUM_BANKS);
  localparam int FOLD_LO_IDX = 1;
  localparam int FOLD_HI_IDX = NUM_BANKS - 1;
  localparam int FOLD_BIT    = DATA_W - 1;
  localparam int LOW_GAP     = ADDR_W - 1 - (WIN_BITS + 1 - HALF_BITS) - HALF_BITS + 1;

  logic [DATA_W-1:0] ctlReg0, ctlReg1;
  logic [DATA_W-1:0] bankReg [NUM_BANKS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg0 <= '0;
      ctlReg1 <= '0;
    end else begin
      if (strobe.wrCtl0) ctlReg0 <= wrData;
      if (strobe.wrCtl1) ctlReg1 <= wrData;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN)                bankReg[b] <= DATA_W'(b);
      else if (strobe.wrBank[b]) bankReg[b] <= wrData & BANK_KEEP;
    end

    // R2: masked bits never hold a one
    p_bank_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
      (bankReg[b] & ~BANK_KEEP) == '0);

    // R10: a write lands on the following edge
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rstN)
      strobe.wrBank[b] |=> bankReg[b] == ($past(wrData) & BANK_KEEP));

    // R10: without a write the register holds
    p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.wrBank[b] |=> $stable(bankReg[b]));
  end

  // read mux
  logic [DATA_W-1:0] regRead;
  always_comb begin
    regRead = '0;
    if (strobe.off == OFF_W'(0)) regRead = ctlReg0;
    if (strobe.off == OFF_W'(1)) regRead = ctlReg1;
    for (int b = 0; b < NUM_BANKS; b++)
      if (strobe.off == OFF_W'(BANK_BASE + b)) regRead = bankReg[b];
  end

  always_comb begin
    if (!strobe.rdEn)      rdData = '0;
    else if (strobe.rdReg) rdData = regRead;
    else                   rdData = romData;
  end

  // high linear region
  logic [SEL_W-1:0]      highSel;
  logic [ADDR_W-1:0]     highAddr;
  assign highSel  = cpuAddr[WIN_BITS +: SEL_W];
  assign highAddr = {bankReg[highSel][BANK_SEL_W-1:0], cpuAddr[WIN_BITS-1:0]};

  // lower half-bank region with optional fold of address bit 21
  logic foldOn, a21;
  logic [ADDR_W-1:0] lowAddr;
  assign foldOn  = cpuAddr[ADDR_W-1] ? bankReg[FOLD_HI_IDX][FOLD_BIT]
                                     : bankReg[FOLD_LO_IDX][FOLD_BIT];
  assign a21     = cpuAddr[WIN_BITS+1] & ~foldOn;
  assign lowAddr = {LOW_GAP'(0), a21, cpuAddr[WIN_BITS:HALF_BITS+1], cpuAddr[HALF_BITS-1:0]};

  always_comb begin
    if (ioSel)                          romAddr = IO_BASE | ADDR_W'(strobe.off);
    else if (cpuAddr[WIN_BITS + SEL_W]) romAddr = highAddr;
    else                                romAddr = lowAddr;
  end

  // R6: in the high region the window offset passes straight through
  p_high_offset_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ioSel && cpuAddr[22]) |-> romAddr[WIN_BITS-1:0] == cpuAddr[WIN_BITS-1:0]);

  // R7: the compacted region never reaches past 2 MiB
  p_low_span_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ioSel && !cpuAddr[22]) |-> romAddr[23:21] == 3'b000);

  // R7: offset inside the half bank passes through unchanged
  p_low_offset_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ioSel && !cpuAddr[22]) |-> romAddr[HALF_BITS-1:0] == cpuAddr[HALF_BITS-1:0]);
endmodule

// File: rtl/bank_rom_mapper.sv
module bank_rom_mapper
  import bankmap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              ioSel,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] romData,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] romAddr
);
  ioStrobe_t strobe;

  bankmap_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ioSel  (ioSel),
    .ioWr   (ioWr),
    .ioRd   (ioRd),
    .ioOff  (cpuAddr[OFF_W-1:0]),
    .strobe (strobe)
  );

  bankmap_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ioSel   (ioSel),
    .wrData  (wrData),
    .cpuAddr (cpuAddr),
    .romData (romData),
    .rdData  (rdData),
    .romAddr (romAddr)
  );

  // R10: reads are silent unless strobed inside the window
  p_read_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(ioSel && ioRd) |-> rdData == '0);

  // R5: inside the window the ROM address points at the window
  p_window_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    ioSel |-> romAddr == (IO_BASE | {20'h0, cpuAddr[3:0]}));
endmodule

// File: tb/bank_rom_mapper_tb.sv
`timescale 1ns/1ps
module bank_rom_mapper_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] cpuAddr = '0;
  logic        ioSel = 1'b0, ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0]  wrData = '0, romData = 8'h5a;
  logic [7:0]  rdData;
  logic [23:0] romAddr;

  int nChecks = 0, nFails = 0;
  logic [7:0] shadow [8];

  always #4 clk = ~clk;

  bank_rom_mapper u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .ioSel(ioSel), .ioWr(ioWr),
    .ioRd(ioRd), .wrData(wrData), .romData(romData), .rdData(rdData), .romAddr(romAddr)
  );

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic ioWrite(input logic [3:0] off, input logic [7:0] d, input logic [19:0] hi);
    @(negedge clk);
    cpuAddr = {hi, off}; ioSel = 1'b1; ioWr = 1'b1; wrData = d;
    @(negedge clk);
    ioWr = 1'b0; ioSel = 1'b0;
    if (off == 0 || off == 1) shadow[off[2:0]] = d;
    else if (off >= 4 && off <= 7) shadow[off[2:0]] = d & 8'h8f;
  endtask

  task automatic ioRead(input logic [3:0] off, input logic [19:0] hi, output logic [7:0] d);
    @(negedge clk);
    cpuAddr = {hi, off}; ioSel = 1'b1; ioRd = 1'b1;
    #1 d = rdData;
    ioRd = 1'b0; ioSel = 1'b0;
  endtask

  function automatic logic [23:0] model(input logic [23:0] a);
    logic [23:0] x;
    logic fold;
    if (a[22]) return {shadow[3'(4 + a[21:20])][3:0], a[19:0]};
    fold = a[23] ? shadow[7][7] : shadow[5][7];
    x = a;
    if (x[21] && fold) x[21] = 1'b0;
    return ((x >> 1) & 24'h1f8000) | (x & 24'h007fff);
  endfunction

  task automatic mapCheck(input string req, input logic [23:0] a);
    @(negedge clk);
    cpuAddr = a; ioSel = 1'b0;
    #1 check(req, romAddr, model(a));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    ioRead(4'h0, 20'h00480, d); check("R1 ctl0", {16'h0, d}, 24'h0);
    ioRead(4'h1, 20'h00480, d); check("R1 ctl1", {16'h0, d}, 24'h0);
    for (int i = 0; i < 4; i++) begin
      ioRead(4'(4 + i), 20'h00480, d); check("R1 bank", {16'h0, d}, 24'(i));
    end
  endtask

  task automatic t_masked();
    logic [7:0] d;
    ioWrite(4'h6, 8'hff, 20'h00480);
    ioRead(4'h6, 20'h00480, d); check("R2 mask ff", {16'h0, d}, 24'h8f);
    ioWrite(4'h6, 8'h72, 20'h00480);
    ioRead(4'h6, 20'h00480, d); check("R2 mask 72", {16'h0, d}, 24'h02);
  endtask

  task automatic t_ctl();
    logic [7:0] d;
    ioWrite(4'h0, 8'hf3, 20'h00480);
    ioWrite(4'h1, 8'h7c, 20'h00480);
    ioRead(4'h0, 20'h00480, d); check("R3 ctl0", {16'h0, d}, 24'hf3);
    ioRead(4'h1, 20'h00480, d); check("R3 ctl1", {16'h0, d}, 24'h7c);
  endtask

  task automatic t_alias();
    logic [7:0] d;
    ioWrite(4'h4, 8'h05, 20'hab12f);
    ioRead(4'h4, 20'h00480, d); check("R4 alias write", {16'h0, d}, 24'h05);
    ioRead(4'h1, 20'h3c7d9, d); check("R4 alias read", {16'h0, d}, 24'h7c);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    for (int o = 0; o < 16; o++) begin
      if (o == 2 || o == 3 || o >= 8) begin
        ioWrite(4'(o), 8'hee, 20'h00480);
        romData = 8'(8'h30 + o);
        ioRead(4'(o), 20'h00480, d); check("R5 rom pass", {16'h0, d}, 24'(8'h30 + o));
      end
    end
    @(negedge clk); cpuAddr = 24'h00480b; ioSel = 1'b1;
    #1 check("R5 window addr", romAddr, 24'h00480b);
    ioSel = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i != 2 && i != 3) begin
        ioRead(4'(i), 20'h00480, d); check("R5 regs untouched", {16'h0, d}, {16'h0, shadow[i]});
      end
    end
  endtask

  task automatic t_high();
    mapCheck("R6 q0", 24'hc12345);
    mapCheck("R6 q1", 24'hd9abcd);
    mapCheck("R6 q2", 24'he00001);
    mapCheck("R6 q3", 24'hffffff);
    check("R6 value", model(24'hc12345), 24'h512345);
  endtask

  task automatic t_low();
    mapCheck("R7 base", 24'h008000);
    mapCheck("R7 top", 24'h3fffff);
    check("R7 value", model(24'h3fffff), 24'h1fffff);
    mapCheck("R7 mid", 24'h15c123);
    mapCheck("R7 hi half", 24'hbfffff);
  endtask

  task automatic t_fold();
    ioWrite(4'h5, 8'h81, 20'h00480);
    mapCheck("R8 fold lo", 24'h3fffff);
    check("R8 value", model(24'h3fffff), 24'h0fffff);
    mapCheck("R8 no21", 24'h1f8000);
    mapCheck("R9 hi unaffected", 24'hbfffff);
    ioWrite(4'h5, 8'h01, 20'h00480);
    ioWrite(4'h7, 8'h83, 20'h00480);
    mapCheck("R9 fold hi", 24'hbfffff);
    check("R9 value", model(24'hbfffff), 24'h0fffff);
    mapCheck("R9 lo unaffected", 24'h3fffff);
  endtask

  task automatic t_timing();
    logic [7:0] d;
    @(negedge clk);
    cpuAddr = 24'h004807; ioSel = 1'b0; ioWr = 1'b1; wrData = 8'h0a;
    @(negedge clk); ioWr = 1'b0;
    ioRead(4'h7, 20'h00480, d); check("R10 no select no write", {16'h0, d}, {16'h0, shadow[7]});
    @(negedge clk);
    cpuAddr = 24'h004807; ioSel = 1'b1; ioWr = 1'b1; wrData = 8'h09;
    #1 check("R10 before edge", romAddr, 24'h004807);
    @(posedge clk); #1 ioWr = 1'b0; ioRd = 1'b1; shadow[7] = 8'h09;
    #1 check("R10 after edge", {16'h0, rdData}, 24'h09);
    ioRd = 1'b0; ioSel = 1'b0;
    #1 check("R10 idle read", {16'h0, rdData}, 24'h0);
  endtask

  initial begin
    shadow[0] = 0; shadow[1] = 0; shadow[2] = 0; shadow[3] = 0;
    shadow[4] = 0; shadow[5] = 1; shadow[6] = 2; shadow[7] = 3;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_masked();
    t_ctl();
    t_alias();
    t_unmapped();
    t_high();
    t_low();
    t_fold();
    t_timing();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule